// File: doc/BRIEF.md
# Mode-Selectable Magnitude Comparator

This block is a purely combinational comparator for two equal-width operands. It reports whether the first operand is greater than the second, equal to it, or less than it. A single mode input chooses how the bit patterns are read: as plain unsigned binary, or as two's-complement signed values. The default width is 4 bits, and the width is a parameter.

Both interpretations use one magnitude comparator over all bits below the most significant one. Only the top bit is treated differently. When the two top bits differ, the result comes straight from those bits, and the mode decides which top-bit value wins. When the top bits agree, the shared low-bit result passes through unchanged. This also holds for two negative operands, because the low bits of a two's-complement number order the same way as its value when the sign is fixed. The block therefore costs one low-bit comparator plus a few gates, not two full comparators and a multiplexer. It is meant to sit inside datapaths that must compare values of either signedness.

Top module: `sgn_mag_cmp`

## Requirements
- R1: With signed_mode_i = 0 and equal top bits, gt_o is 1 exactly when a_i is greater than b_i as an unsigned number.
- R2: With signed_mode_i = 1 and differing top (sign) bits, gt_o is 1 exactly when a_i has sign bit 0, that is, the non-negative operand is the larger.
- R3: With signed_mode_i = 1 and equal sign bits, gt_o follows the unsigned comparison of the bits below the sign bit. This holds for negative pairs too: 4'b1111 (-1) > 4'b1100 (-4) > 4'b1001 (-7).
- R4: With signed_mode_i = 0 and differing top bits, gt_o is 1 exactly when a_i has top bit 1.
- R5: When a_i equals b_i, gt_o and lt_o are 0 in both modes.
- R6: eq_o is 1 exactly when a_i and b_i are bit-identical, in either mode.
- R7: lt_o is 1 exactly when b_i is greater than a_i under the selected interpretation. Exactly one of gt_o, eq_o and lt_o is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| signed_mode_i | input | 1 | 1 = two's-complement signed, 0 = unsigned |
| gt_o | output | 1 | a_i greater than b_i |
| eq_o | output | 1 | a_i equal to b_i |
| lt_o | output | 1 | a_i less than b_i |

## Verification
Immediate assertions are re-evaluated whenever an input changes. They check the shared low-bit comparator against a plain relational result. They also check that the three flags are always one-hot, and that the final greater/less flags match a direct signed or unsigned comparison in the current mode. The bench covers the rest. It sweeps every operand pair in both modes and sorts each result by which top-bit rule applies. This shows that the sign-bit override, the shared low-bit path for negative pairs, and the equal-operand cases each take the correct branch.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic eq;
  } cmp_flags_t;
endpackage

// File: rtl/cmp_low_mag.sv
// Unsigned magnitude compare of the bits below the MSB, shared by both modes.
module cmp_low_mag
  import cmp_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_flags_t   res_o
);
  logic [W-1:0] bit_gt;
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_gt[i] = a_i[i] & ~b_i[i];
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end

  // scan from MSB: first differing bit decides
  always_comb begin
    logic gt_acc, eq_acc;
    gt_acc = 1'b0;
    eq_acc = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      gt_acc = gt_acc | (eq_acc & bit_gt[i]);
      eq_acc = eq_acc & bit_eq[i];
    end
    res_o.gt = gt_acc;
    res_o.eq = eq_acc;
  end

  always_comb begin
    assert_low_gt_R3: assert (res_o.gt == (a_i > b_i))
      else $error("low gt mismatch");
    assert_low_eq_R6: assert (res_o.eq == (a_i == b_i))
      else $error("low eq mismatch");
  end
endmodule

// File: rtl/cmp_msb_sel.sv
// Applies the top-bit rule for the selected mode on top of the shared low result.
module cmp_msb_sel
  import cmp_pkg::*;
(
  input  logic       a_msb_i,
  input  logic       b_msb_i,
  input  cmp_mode_e  mode_i,
  input  cmp_flags_t low_i,
  output logic       gt_o,
  output logic       eq_o,
  output logic       lt_o
);
  logic msb_diff;
  logic top_win;

  assign msb_diff = a_msb_i ^ b_msb_i;
  // unsigned: a wins with MSB 1; signed: a wins with sign 0
  assign top_win  = (mode_i == MODE_SIGNED) ? ~a_msb_i : a_msb_i;

  always_comb begin
    if (msb_diff) begin
      gt_o = top_win;
      eq_o = 1'b0;
    end else begin
      gt_o = low_i.gt;
      eq_o = low_i.eq;
    end
    lt_o = ~gt_o & ~eq_o;
  end

  always_comb begin
    if (msb_diff) begin
      assert_diff_msb_no_eq_R6: assert (!eq_o) else $error("eq with differing MSB");
      if (mode_i == MODE_SIGNED) begin
        assert_sign_rule_R2: assert (gt_o == b_msb_i) else $error("signed MSB rule");
      end else begin
        assert_unsigned_msb_R4: assert (gt_o == a_msb_i) else $error("unsigned MSB rule");
      end
    end
  end
endmodule

// File: rtl/sgn_mag_cmp.sv
module sgn_mag_cmp
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             signed_mode_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);
  localparam int unsigned LowW = WIDTH - 1;
  localparam int unsigned MsbI = WIDTH - 1;

  cmp_mode_e  mode;
  cmp_flags_t low_res;

  assign mode = cmp_mode_e'(signed_mode_i);

  cmp_low_mag #(.W(LowW)) u_low (
    .a_i   (a_i[LowW-1:0]),
    .b_i   (b_i[LowW-1:0]),
    .res_o (low_res)
  );

  cmp_msb_sel u_msb (
    .a_msb_i (a_i[MsbI]),
    .b_msb_i (b_i[MsbI]),
    .mode_i  (mode),
    .low_i   (low_res),
    .gt_o    (gt_o),
    .eq_o    (eq_o),
    .lt_o    (lt_o)
  );

  always_comb begin
    assert_one_flag_R7: assert ($countones({gt_o, eq_o, lt_o}) == 1)
      else $error("flags not one-hot");
    if (a_i == b_i) begin
      assert_equal_no_gt_R5: assert (!gt_o && !lt_o && eq_o)
        else $error("equal operands misreported");
    end
    if (signed_mode_i) begin
      assert_signed_ref_R3: assert (gt_o == ($signed(a_i) > $signed(b_i)))
        else $error("signed compare mismatch");
    end else begin
      assert_unsigned_ref_R1: assert (gt_o == (a_i > b_i))
        else $error("unsigned compare mismatch");
    end
  end
endmodule

// File: tb/sgn_mag_cmp_tb.sv
module sgn_mag_cmp_tb;
  localparam int W = 4;
  localparam int N = 1 << W;

  typedef struct {
    logic  gt;
    logic  eq;
    logic  lt;
    string gt_req;
    int    a;
    int    b;
    int    md;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic         smode;
  logic         gt, eq, lt;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   drv_done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  sgn_mag_cmp #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .signed_mode_i(smode),
    .gt_o(gt), .eq_o(eq), .lt_o(lt)
  );

  function automatic int to_val(int v, int md);
    if (md != 0 && v >= N / 2) return v - N;
    return v;
  endfunction

  task automatic drive(int av, int bv, int md);
    exp_t e;
    int   sa, sb;
    @(posedge clk);
    #1;
    a = W'(av); b = W'(bv); smode = md[0];
    sa = to_val(av, md);
    sb = to_val(bv, md);
    e.gt = sa > sb;
    e.eq = av == bv;
    e.lt = sa < sb;
    e.a = av; e.b = bv; e.md = md;
    if (av == bv) e.gt_req = "R5";
    else if (((av ^ bv) >> (W - 1)) & 1) e.gt_req = (md != 0) ? "R2" : "R4";
    else e.gt_req = (md != 0) ? "R3" : "R1";
    q.push_back(e);
  endtask

  task automatic check(string req, logic act, logic exp, exp_t e, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s a=%0h b=%0h mode=%0d actual=%0b expected=%0b",
               req, what, e.a, e.b, e.md, act, exp);
    end
  endtask

  // monitor: pops and compares on the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.gt_req, gt, e.gt, e, "gt");
        check("R6", eq, e.eq, e, "eq");
        check("R7", lt, e.lt, e, "lt");
      end
    end
  end

  initial begin
    a = '0; b = '0; smode = 1'b0;
    #10 rst_ni = 1'b1;
    // R3 negative ordering examples: -1 > -4 > -7
    drive(4'hF, 4'hC, 1);
    drive(4'hC, 4'h9, 1);
    drive(4'h9, 4'hF, 1);
    // R2 sign override, R4 unsigned MSB
    drive(4'h7, 4'h8, 1);
    drive(4'h7, 4'h8, 0);
    for (int md = 0; md < 2; md++)
      for (int av = 0; av < N; av++)
        for (int bv = 0; bv < N; bv++)
          drive(av, bv, md);
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done && q.size() == 0);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule